// File: doc/BRIEF.md
# Frequency-Corrected Quadrature Generator

This block derives an orthogonal (beta) companion for a single sampled waveform (alpha) from a circular sample delay whose length is one quarter of the nominal line period. With the default configuration this is 100 samples: a 50 Hz nominal line sampled at 20 kHz. When the line runs off nominal, a fixed delay no longer gives a 90-degree shift. The raw delayed value then carries both a gain error and a leak of the present alpha sample. A phase-locked loop that uses this raw value settles with a constant phase offset and a ripple at twice the line frequency.

An external frequency tracker supplies `eps_in`, its estimate of the relative frequency deviation. The block takes a small angle equal to a quarter turn times that estimate. It works out the sine and cosine of that angle with short polynomials. It then forms (raw + alpha·sin) / cos, using the present alpha sample, and divides with a bit-serial divider. The result is a corrected quadrature sample that stays in step with alpha, and it is presented with a one-cycle valid pulse. New samples must arrive no more often than once every 2·DW+2 clock cycles.

Top module: `fcq_beta_gen`

## Requirements
- R1: The raw quadrature value used for accepted sample n is the alpha value accepted DEPTH samples earlier. With eps_in = 0, beta_out equals that value bit for bit.
- R2: For a nonzero estimate, beta_out is within 4 LSB of (raw + alpha·sin(θ)) / cos(θ), saturated to the signed DW-bit range. Here θ = (π/2)·e / 2^(DW-1), and e is eps_in read as signed Q1.(DW-1).
- R3: An estimate of exactly zero gives a sine term of 0 and a cosine term of exactly 1.0 (2^(DW-1)), so no correction is applied.
- R4: eps_in is clamped to ±ELIM before use. An estimate beyond the limit gives the same result as the limit with the same sign.
- R5: A corrected value that exceeds the signed DW-bit range saturates to 2^(DW-1)−1 or −2^(DW-1).
- R6: out_vld is a single-cycle pulse. It rises 2·DW+2 clock edges after the edge that accepted the sample. beta_out changes only together with out_vld.
- R7: After reset, out_vld is 0, beta_out is 0 and the delay line is empty. The first DEPTH accepted samples produce no output.
- R8: The correction uses the alpha sample that arrives with the same in_vld, not the delayed one. A positive estimate therefore adds a positive multiple of the present alpha.
- R9: Truncation is symmetric about zero. When every alpha sample is negated, every unsaturated output is negated exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Accepts alpha_in and eps_in on this edge |
| alpha_in | input | DW | Present alpha sample, signed |
| eps_in | input | DW | Estimated relative frequency deviation, signed Q1.(DW-1) |
| beta_out | output | DW | Corrected quadrature sample, signed |
| out_vld | output | 1 | One-cycle strobe marking a new beta_out |

## Verification
A wrong write pointer or fill count in the delay line shows up on the first output after fill: with a zero estimate, beta_out no longer equals the alpha value from exactly DEPTH samples before. A fault in the sine or cosine polynomial, or a misplaced sign, moves every nonzero-estimate output by more than a few LSB. This appears in the very next result, 2·DW+2 cycles after the sample. A divider that loses or gains a step breaks either the fixed latency or the exact negation between streams of opposite sign, and it does so on the first affected sample.

// File: rtl/fcq_pkg.sv
package fcq_pkg;
  typedef enum logic {
    DV_IDLE = 1'b0,
    DV_RUN  = 1'b1
  } dv_state_e;

  function automatic int unsigned prod_width(int unsigned dw);
    return 2 * dw;
  endfunction
endpackage

// File: rtl/fcq_delay_line.sv
module fcq_delay_line #(
  parameter int DW    = 16,
  parameter int DEPTH = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout,
  output logic                 full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic signed [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_n;
  logic [FW-1:0] fill_q, fill_n;

  assign dout = mem[wptr_q];
  assign full = (fill_q == FW'(DEPTH));

  always_comb begin
    wptr_n = wptr_q;
    fill_n = fill_q;
    if (en) begin
      wptr_n = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (!full) fill_n = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      wptr_q <= wptr_n;
      fill_q <= fill_n;
      if (en) mem[wptr_q] <= din;
    end
  end
endmodule

// File: rtl/fcq_small_trig.sv
module fcq_small_trig #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] eps_i,
  output logic signed [DW-1:0] sin_o,
  output logic        [DW-1:0] cos_o
);
  localparam int FR   = DW - 1;
  localparam int LW   = 2 * DW + 4;
  localparam int HPI  = $rtoi(1.5707963267948966 * (2.0 ** FR) + 0.5);
  localparam int INV6 = $rtoi((2.0 ** FR) / 6.0 + 0.5);
  localparam logic signed [LW-1:0] HPI_L  = LW'(HPI);
  localparam logic signed [LW-1:0] INV6_L = LW'(INV6);
  localparam logic signed [LW-1:0] ONE_L  = LW'(1) <<< FR;

  logic signed [LW-1:0] e_l, ang, ang2, ang3, s_l, c_l;

  always_comb begin
    e_l   = LW'(eps_i);
    ang   = (e_l * HPI_L) >>> FR;
    ang2  = (ang * ang) >>> FR;
    ang3  = (ang2 * ang) >>> FR;
    s_l   = ang - ((ang3 * INV6_L) >>> FR);
    c_l   = ONE_L - (ang2 >>> 1);
    sin_o = DW'(s_l);
    cos_o = DW'(c_l);
  end
endmodule

// File: rtl/fcq_divider.sv
module fcq_divider #(
  parameter int DW = 16,
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  input  logic          neg_i,
  output logic [NW-1:0] quo_o,
  output logic          neg_o,
  output logic          done_o,
  output logic          busy_o
);
  import fcq_pkg::*;
  localparam int CW = $clog2(NW);

  dv_state_e     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] rem_q, rem_n, den_q, den_n;
  logic [NW-1:0] quo_q, quo_n;
  logic          neg_q, neg_n, done_q, done_n;
  logic [DW:0]   rem_sh, diff;
  logic          ge;

  always_comb begin
    rem_sh = {rem_q, quo_q[NW-1]};
    diff   = rem_sh - {1'b0, den_q};
    ge     = (rem_sh >= {1'b0, den_q});
    st_n   = st_q;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    quo_n  = quo_q;
    den_n  = den_q;
    neg_n  = neg_q;
    done_n = 1'b0;
    if (start) begin
      st_n  = DV_RUN;
      cnt_n = '0;
      rem_n = '0;
      quo_n = num_i;
      den_n = den_i;
      neg_n = neg_i;
    end else if (st_q == DV_RUN) begin
      rem_n = ge ? DW'(diff) : DW'(rem_sh);
      quo_n = {quo_q[NW-2:0], ge};
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CW'(NW - 1)) begin
        st_n   = DV_IDLE;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DV_IDLE;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      den_q  <= den_n;
      neg_q  <= neg_n;
      done_q <= done_n;
    end
  end

  assign quo_o  = quo_q;
  assign neg_o  = neg_q;
  assign done_o = done_q;
  assign busy_o = (st_q == DV_RUN);
endmodule

// File: rtl/fcq_beta_gen.sv
module fcq_beta_gen #(
  parameter int DW    = 16,
  parameter int DEPTH = 100,
  parameter int ELIM  = 3277
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] alpha_in,
  input  logic signed [DW-1:0] eps_in,
  output logic signed [DW-1:0] beta_out,
  output logic                 out_vld
);
  localparam int FR = DW - 1;
  localparam int NW = int'(fcq_pkg::prod_width(DW));
  localparam logic signed [DW-1:0] LIM_P = DW'(ELIM);
  localparam logic signed [DW-1:0] LIM_N = -LIM_P;
  localparam logic [NW-1:0] MAXP = NW'((2 ** (DW - 1)) - 1);

  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic signed [DW-1:0] raw_w, sin_w;
  logic        [DW-1:0] cos_w;
  logic                 full_w;

  fcq_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_sn), .en(in_vld),
    .din(alpha_in), .dout(raw_w), .full(full_w)
  );

  logic signed [DW-1:0] alpha_q, alpha_n, raw_q, raw_n, eps_q, eps_n, eps_c;
  logic                 st_vld_q, st_vld_n;

  always_comb begin
    if (eps_in > LIM_P)      eps_c = LIM_P;
    else if (eps_in < LIM_N) eps_c = LIM_N;
    else                     eps_c = eps_in;
    alpha_n  = in_vld ? alpha_in : alpha_q;
    raw_n    = in_vld ? raw_w : raw_q;
    eps_n    = in_vld ? eps_c : eps_q;
    st_vld_n = in_vld && full_w;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      alpha_q  <= '0;
      raw_q    <= '0;
      eps_q    <= '0;
      st_vld_q <= 1'b0;
    end else begin
      alpha_q  <= alpha_n;
      raw_q    <= raw_n;
      eps_q    <= eps_n;
      st_vld_q <= st_vld_n;
    end
  end

  fcq_small_trig #(.DW(DW)) u_trig (.eps_i(eps_q), .sin_o(sin_w), .cos_o(cos_w));

  logic signed [NW:0]   num_s;
  logic        [NW-1:0] num_mag, quo_w;
  logic                 div_neg, div_done, div_busy;

  always_comb begin
    num_s   = ((NW + 1)'(raw_q) <<< FR) + ((NW + 1)'(alpha_q) * (NW + 1)'(sin_w));
    num_mag = num_s[NW] ? NW'(-num_s) : NW'(num_s);
  end

  fcq_divider #(.DW(DW), .NW(NW)) u_div (
    .clk(clk), .rst_n(rst_sn), .start(st_vld_q),
    .num_i(num_mag), .den_i(cos_w), .neg_i(num_s[NW]),
    .quo_o(quo_w), .neg_o(div_neg), .done_o(div_done), .busy_o(div_busy)
  );

  logic signed [DW-1:0] beta_n, sat_w;
  logic                 out_vld_n;

  always_comb begin
    if (!div_neg) sat_w = (quo_w > MAXP) ? DW'(MAXP) : DW'(quo_w);
    else          sat_w = (quo_w > MAXP + 1'b1) ? {1'b1, {(DW-1){1'b0}}} : DW'(-quo_w);
    beta_n    = div_done ? sat_w : beta_out;
    out_vld_n = div_done;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      beta_out <= '0;
      out_vld  <= 1'b0;
    end else begin
      beta_out <= beta_n;
      out_vld  <= out_vld_n;
    end
  end
endmodule

// File: rtl/fcq_beta_gen_chk.sv
module fcq_beta_gen_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 100,
  parameter int ELIM  = 3277
) (
  input logic                 clk,
  input logic                 rst_sn,
  input logic                 in_vld,
  input logic                 out_vld,
  input logic signed [DW-1:0] beta_out,
  input logic                 st_vld,
  input logic signed [DW-1:0] eps_q,
  input logic signed [DW-1:0] sin_w,
  input logic        [DW-1:0] cos_w,
  input logic                 div_busy
);
  localparam int AW = $clog2(DEPTH + 2);
  localparam logic [DW-1:0] ONE = DW'(1) << (DW - 1);
  localparam logic signed [DW-1:0] LIM_P = DW'(ELIM);

  logic [AW-1:0] acc_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) acc_q <= '0;
    else if (in_vld && acc_q <= AW'(DEPTH)) acc_q <= acc_q + 1'b1;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    !out_vld |-> $stable(beta_out));
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    out_vld |=> !out_vld);
  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    st_vld |-> (acc_q > AW'(DEPTH)));
  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_vld && eps_q == '0) |-> (cos_w == ONE && sin_w == '0));
  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    st_vld |-> (eps_q <= LIM_P && eps_q >= -LIM_P && cos_w > (ONE >> 1)));
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(div_busy) |-> $past(st_vld));
endmodule

bind fcq_beta_gen fcq_beta_gen_chk #(.DW(DW), .DEPTH(DEPTH), .ELIM(ELIM)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .in_vld(in_vld), .out_vld(out_vld),
  .beta_out(beta_out), .st_vld(st_vld_q), .eps_q(eps_q),
  .sin_w(sin_w), .cos_w(cos_w), .div_busy(div_busy)
);

// File: tb/fcq_beta_gen_test.sv
module fcq_beta_gen_test;
  localparam int DW = 16, DEPTH = 100, ELIM = 3277;
  localparam int LAT = 2 * DW + 2;
  localparam int NS = 420, NNEG = 300;

  logic clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0;
  logic signed [DW-1:0] alpha_in = '0, eps_in = '0;
  logic signed [DW-1:0] beta_out;
  logic out_vld;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  int res1 [NS];

  always #2 clk = ~clk;

  fcq_beta_gen #(.DW(DW), .DEPTH(DEPTH), .ELIM(ELIM)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .alpha_in(alpha_in),
    .eps_in(eps_in), .beta_out(beta_out), .out_vld(out_vld)
  );

  function automatic int alpha_of(int n, bit neg);
    int a;
    if (n < 300)      a = ((n * 7919 + 123) % 40001) - 20000;
    else if (n < 410) a = 32767;
    else              a = -32768;
    return neg ? -a : a;
  endfunction

  function automatic int eps_of(int n);
    if (n < 200) return 0;
    if (n < 280) return ((n % 41) - 20) * 160;
    if (n < 300) return (n % 2) ? 20000 : -20000;
    if (n < 400) return 0;
    if (n < 405) return ELIM;
    if (n < 410) return 20000;
    return ELIM;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R7 out_vld after reset", int'(out_vld), 0);
    check(beta_out == '0, "R7 beta_out after reset", int'(beta_out), 0);
  endtask

  task automatic do_sample(int n, bit neg);
    int a, e, ec, lat, raw, got;
    real th, ev;
    a = alpha_of(n, neg);
    e = eps_of(n);
    @(negedge clk);
    alpha_in = DW'(a);
    eps_in   = DW'(e);
    in_vld   = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    lat = 0;
    while (!out_vld && lat < LAT + 6) begin
      @(negedge clk);
      lat++;
    end
    if (n < DEPTH) begin
      check(out_vld == 1'b0, "R7 no output before fill", int'(out_vld), 0);
      return;
    end
    check(lat == LAT, "R6 latency", lat, LAT);
    got = int'(beta_out);
    raw = alpha_of(n - DEPTH, neg);
    if (neg && n < NNEG)
      check(got == -res1[n], "R9 negated stream", got, -res1[n]);
    if (!neg) res1[n] = got;
    if (e == 0) begin
      check(got == raw, "R1/R3 zero estimate passes raw", got, raw);
    end else begin
      ec = (e > ELIM) ? ELIM : ((e < -ELIM) ? -ELIM : e);
      th = 3.14159265358979 / 2.0 * real'(ec) / 32768.0;
      ev = (real'(raw) + real'(a) * $sin(th)) / $cos(th);
      if (ev > 32767.0) ev = 32767.0;
      if (ev < -32768.0) ev = -32768.0;
      if (ev >= 32767.0 || ev <= -32768.0)
        check(got >= int'(ev) - 4 && got <= int'(ev) + 4, "R5 saturation", got, int'(ev));
      else if (e != ec)
        check(got >= int'(ev) - 4 && got <= int'(ev) + 4, "R4 clamped estimate", got, int'(ev));
      else
        check(got >= int'(ev) - 4 && got <= int'(ev) + 4, "R2/R8 corrected value", got, int'(ev));
    end
    @(negedge clk);
    check(out_vld == 1'b0, "R6 single-cycle strobe", int'(out_vld), 0);
    check(int'(beta_out) == got, "R6 output held", int'(beta_out), got);
  endtask

  initial begin
    do_reset();
    for (int n = 0; n < NS; n++) do_sample(n, 1'b0);
    do_reset();
    for (int n = 0; n < NNEG; n++) do_sample(n, 1'b1);
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule